// File: doc/BRIEF.md
# Global Time Counter Synchronizer

This block keeps a node's local copy of a shared time count. The count steps by one on every edge of an externally distributed reference clock, nominally 62.5 MHz, which is the block's only clock. A controller elsewhere aligns the nodes by comparing when each one reacts to a chosen count value. The controller reaches the block through a small write/read register port.

To align, software turns on synchronization mode. While that mode is on, front-end samples and self-triggers are held back from the outputs. Software programs a target count, and the block puts a one-cycle technical trigger on the trigger line in the very cycle its counter shows that value. An upstream unit measures how far apart the nodes' triggers arrive. Software then writes a signed correction, which is added to the running count. A second target confirms the alignment, and software turns synchronization mode off.

The correction is applied in a single cycle and does not lose that cycle's increment. A status bit holds the fact that a trigger fired until software clears it. A target that is already behind the counter fires only after the counter wraps around.

Top module: `gtime_sync`

## Requirements
- R1: While reset is asserted, the count reads 0, synchronization mode is off, the status bit is 0, and `out_valid` and `trig_out` are 0.
- R2: With no correction written, the count grows by exactly one on each clock, modulo 2^CNT_W.
- R3: A write to register 2 (correction) makes the next count equal to the old count + 1 + the written value, where the written value is taken as two's complement and the sum is modulo 2^CNT_W.
- R4: Bit 0 of register 0 (control) turns synchronization mode on (1) or off (0), and a read of register 0 returns that bit in bit 0.
- R5: While synchronization mode is on, a front-end sample or self-trigger never reaches `out_valid` or `trig_out`, and `out_data` keeps its last value.
- R6: While synchronization mode is off, a front-end sample and a self-trigger appear on `out_data`/`out_valid` and `trig_out` one cycle after they are presented.
- R7: In synchronization mode, with the trigger armed, `trig_out` is high for exactly one cycle, and that is the cycle in which the count read from register 3 equals the target.
- R8: Once the technical trigger fires, it is disarmed and does not fire again. Writing register 1 (target) re-arms it, so a second target verifies the alignment.
- R9: Firing sets a status bit, read as bit 1 of register 0. The bit stays set until a write to register 0 with bit 1 set clears it.
- R10: A target written when it is not at least two counts ahead of the current count does not fire until the counter wraps around and reaches it.
- R11: With synchronization mode off, an armed target that the count passes through produces no technical trigger and does not set the status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that also advances the count |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 target, 2 correction, 3 count |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for the selected register, combinational |
| fe_data | input | DATA_W | Front-end sample |
| fe_valid | input | 1 | Front-end sample qualifier |
| fe_trig | input | 1 | Front-end self-trigger |
| out_data | output | DATA_W | Forwarded sample |
| out_valid | output | 1 | Forwarded sample qualifier |
| trig_out | output | 1 | Trigger line: forwarded self-trigger or technical trigger |

## Verification
The bench builds the block with CNT_W = 16 and DATA_W = 16. The narrow counter wraps after 65,536 cycles, so a target written behind the count can be watched until it fires after the wrap. The same width lets a negative correction be seen to wrap below zero. Every other case uses the same logic as the 48-bit default, just with a shorter carry chain.

// File: rtl/gts_pkg.sv
package gts_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_TARGET = 2'd1,
        REG_CORR   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    localparam int CTRL_SYNC_BIT  = 0;
    localparam int CTRL_FLAG_BIT  = 1;

endpackage

// File: rtl/gts_counter.sv
module gts_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (add_en) begin
            s_d.cnt = s_q.cnt + STEP + add_val;
        end else begin
            s_d.cnt = s_q.cnt + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q   = s_q.cnt;
    assign cnt_nxt = s_d.cnt;

endmodule

// File: rtl/gts_regs.sv
module gts_regs
    import gts_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             flag_q,
    output logic             sync_q,
    output logic [CNT_W-1:0] target_q,
    output logic             target_wr,
    output logic             corr_wr,
    output logic [CNT_W-1:0] corr_val,
    output logic             flag_clr
);

    typedef struct packed {
        logic             sync;
        logic [CNT_W-1:0] target;
        logic [CNT_W-1:0] corr;
    } reg_state_t;

    reg_state_t s_d, s_q;
    reg_sel_e   sel;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        s_d       = s_q;
        target_wr = 1'b0;
        corr_wr   = 1'b0;
        flag_clr  = 1'b0;
        if (reg_we) begin
            case (sel)
                REG_CTRL: begin
                    s_d.sync = reg_wdata[CTRL_SYNC_BIT];
                    flag_clr = reg_wdata[CTRL_FLAG_BIT];
                end
                REG_TARGET: begin
                    s_d.target = reg_wdata;
                    target_wr  = 1'b1;
                end
                REG_CORR: begin
                    s_d.corr = reg_wdata;
                    corr_wr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CTRL: begin
                reg_rdata[CTRL_SYNC_BIT] = s_q.sync;
                reg_rdata[CTRL_FLAG_BIT] = flag_q;
            end
            REG_TARGET: reg_rdata = s_q.target;
            REG_CORR:   reg_rdata = s_q.corr;
            default:    reg_rdata = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_q   = s_q.sync;
    assign target_q = s_q.target;
    assign corr_val = reg_wdata;

endmodule

// File: rtl/gts_trigger.sv
module gts_trigger #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] target_q,
    input  logic             target_wr,
    input  logic             sync_q,
    input  logic             flag_clr,
    output logic             tech_q,
    output logic             flag_q
);

    typedef struct packed {
        logic armed;
        logic tech;
        logic flag;
    } trg_state_t;

    trg_state_t s_d, s_q;
    logic       hit;

    always_comb begin
        hit = sync_q && s_q.armed && (cnt_nxt == target_q);
        s_d = s_q;
        s_d.tech = hit;
        if (target_wr) begin
            s_d.armed = 1'b1;
        end else if (hit) begin
            s_d.armed = 1'b0;
        end
        s_d.flag = hit || (s_q.flag && !flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tech_q = s_q.tech;
    assign flag_q = s_q.flag;

endmodule

// File: rtl/gts_gate.sv
module gts_gate #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_q,
    input  logic [DATA_W-1:0] fe_data,
    input  logic              fe_valid,
    input  logic              fe_trig,
    input  logic              tech_q,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              trig_out
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              trig;
    } gate_state_t;

    gate_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = fe_valid && !sync_q;
        s_d.trig  = fe_trig && !sync_q;
        if (fe_valid && !sync_q) begin
            s_d.data = fe_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data  = s_q.data;
    assign out_valid = s_q.valid;
    assign trig_out  = s_q.trig || tech_q;

endmodule

// File: rtl/gtime_sync.sv
module gtime_sync #(
    parameter int CNT_W  = 48,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [DATA_W-1:0] fe_data,
    input  logic              fe_valid,
    input  logic              fe_trig,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              trig_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] corr_val;
    logic             corr_wr;
    logic             target_wr;
    logic             sync_q;
    logic             flag_q;
    logic             flag_clr;
    logic             tech_q;

    gts_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (corr_wr),
        .add_val (corr_val),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    gts_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_q     (cnt_q),
        .flag_q    (flag_q),
        .sync_q    (sync_q),
        .target_q  (target_q),
        .target_wr (target_wr),
        .corr_wr   (corr_wr),
        .corr_val  (corr_val),
        .flag_clr  (flag_clr)
    );

    gts_trigger #(.CNT_W(CNT_W)) u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_nxt   (cnt_nxt),
        .target_q  (target_q),
        .target_wr (target_wr),
        .sync_q    (sync_q),
        .flag_clr  (flag_clr),
        .tech_q    (tech_q),
        .flag_q    (flag_q)
    );

    gts_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_q    (sync_q),
        .fe_data   (fe_data),
        .fe_valid  (fe_valid),
        .fe_trig   (fe_trig),
        .tech_q    (tech_q),
        .out_data  (out_data),
        .out_valid (out_valid),
        .trig_out  (trig_out)
    );

endmodule

// File: rtl/gts_checker.sv
module gts_checker #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             add_en,
    input logic [CNT_W-1:0] add_val,
    input logic             sync,
    input logic [CNT_W-1:0] target,
    input logic             tech,
    input logic             flag,
    input logic             out_valid
);

    // R2: plain step of one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    // R3: correction added on top of the step
    a_r3_corr_added: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> cnt == CNT_W'($past(cnt) + CNT_W'(1) + $past(add_val)));

    // R5: no forwarded sample in synchronization mode
    a_r5_sample_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !out_valid);

    // R7: technical trigger lands on the target count
    a_r7_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        tech |-> cnt == $past(target));

    // R9: firing leaves the status bit set
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tech |-> flag);

    // R11: technical trigger only from synchronization mode
    a_r11_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
        tech |-> $past(sync));

endmodule

bind gtime_sync gts_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .add_en    (corr_wr),
    .add_val   (corr_val),
    .sync      (sync_q),
    .target    (target_q),
    .tech      (tech_q),
    .flag      (flag_q),
    .out_valid (out_valid)
);

// File: tb/gtime_sync_bench.sv
module gtime_sync_bench;
    import gts_pkg::*;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = REG_COUNT;
    logic [CNT_W-1:0]  reg_wdata = '0;
    logic [CNT_W-1:0]  reg_rdata;
    logic [DATA_W-1:0] fe_data = '0;
    logic              fe_valid = 1'b0;
    logic              fe_trig = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;
    logic              trig_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gtime_sync #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_gtime_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fe_data   (fe_data),
        .fe_valid  (fe_valid),
        .fe_trig   (fe_trig),
        .out_data  (out_data),
        .out_valid (out_valid),
        .trig_out  (trig_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called shortly after a falling edge; returns after the next one
    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we   = 1'b0;
        reg_addr = REG_COUNT;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] v;
        repeat (3) @(negedge clk);
        rd(REG_COUNT, v);
        check(v == 0, "R1 count", v, 0);
        rd(REG_CTRL, v);
        check(v == 0, "R1 control", v, 0);
        check(out_valid == 0 && trig_out == 0, "R1 outputs", {out_valid, trig_out}, 0);
        reg_addr = REG_COUNT;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_count;
        logic [CNT_W-1:0] c0, c1;
        rd(REG_COUNT, c0);
        @(negedge clk);
        rd(REG_COUNT, c1);
        check(c1 == CNT_W'(c0 + 1), "R2 single step", c1, CNT_W'(c0 + 1));
        repeat (5) @(negedge clk);
        rd(REG_COUNT, c1);
        check(c1 == CNT_W'(c0 + 6), "R2 six steps", c1, CNT_W'(c0 + 6));
    endtask

    task automatic t_corr(input logic [CNT_W-1:0] off, input string tag);
        logic [CNT_W-1:0] c0, c1, e;
        rd(REG_COUNT, c0);
        wr(REG_CORR, off);
        rd(REG_COUNT, c1);
        e = CNT_W'(c0 + 1 + off);
        check(c1 == e, tag, c1, e);
    endtask

    task automatic t_gate;
        logic [CNT_W-1:0] v;
        fe_valid = 1'b1; fe_data = 16'hA5C3; fe_trig = 1'b1;
        @(negedge clk);
        fe_valid = 1'b0; fe_trig = 1'b0;
        check(out_valid && out_data == 16'hA5C3, "R6 sample forwarded", out_data, 16'hA5C3);
        check(trig_out == 1, "R6 self-trigger forwarded", trig_out, 1);
        @(negedge clk);
        check(out_valid == 0 && trig_out == 0, "R6 single cycle", {out_valid, trig_out}, 0);
        wr(REG_CTRL, 16'h0001);
        rd(REG_CTRL, v);
        check(v[0] == 1, "R4 sync on readback", v[0], 1);
        fe_valid = 1'b1; fe_data = 16'h1234; fe_trig = 1'b1;
        @(negedge clk);
        fe_valid = 1'b0; fe_trig = 1'b0;
        check(out_valid == 0, "R5 sample blocked", out_valid, 0);
        check(trig_out == 0, "R5 self-trigger blocked", trig_out, 0);
        check(out_data == 16'hA5C3, "R5 data held", out_data, 16'hA5C3);
        wr(REG_CTRL, 16'h0000);
        rd(REG_CTRL, v);
        check(v[0] == 0, "R4 sync off readback", v[0], 0);
    endtask

    // counts cycles where trig_out disagrees with (count == tgt)
    task automatic watch(input logic [CNT_W-1:0] tgt, input int n, output int hits, output int bad);
        logic [CNT_W-1:0] cc;
        hits = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            rd(REG_COUNT, cc);
            if (trig_out) hits++;
            if (trig_out != (cc == tgt)) bad++;
            @(negedge clk);
        end
    endtask

    task automatic t_fire;
        logic [CNT_W-1:0] c, p, v;
        int hits, bad;
        wr(REG_CTRL, 16'h0001);
        rd(REG_COUNT, c);
        p = CNT_W'(c + 10);
        wr(REG_TARGET, p);
        watch(p, 20, hits, bad);
        check(hits == 1 && bad == 0, "R7 one pulse on target", hits, 1);
        watch(p, 30, hits, bad);
        check(hits == 0, "R8 disarmed after firing", hits, 0);
        rd(REG_CTRL, v);
        check(v[1] == 1, "R9 status set", v[1], 1);
        wr(REG_CTRL, 16'h0003);
        rd(REG_CTRL, v);
        check(v[1] == 0, "R9 status cleared", v[1], 0);
        check(v[0] == 1, "R4 sync kept by clear", v[0], 1);
        rd(REG_COUNT, c);
        p = CNT_W'(c + 5);
        wr(REG_TARGET, p);
        watch(p, 10, hits, bad);
        check(hits == 1 && bad == 0, "R8 re-armed second target", hits, 1);
    endtask

    task automatic t_nosync;
        logic [CNT_W-1:0] c, p, v;
        int hits, bad;
        wr(REG_CTRL, 16'h0002);
        rd(REG_COUNT, c);
        p = CNT_W'(c + 6);
        wr(REG_TARGET, p);
        watch(p, 12, hits, bad);
        check(hits == 0, "R11 no trigger outside sync", hits, 0);
        rd(REG_CTRL, v);
        check(v[1] == 0, "R11 status untouched", v[1], 0);
    endtask

    task automatic t_past;
        logic [CNT_W-1:0] c, p;
        int hits, bad;
        wr(REG_CTRL, 16'h0001);
        rd(REG_COUNT, c);
        p = CNT_W'(c - 5);
        wr(REG_TARGET, p);
        watch(p, 200, hits, bad);
        check(hits == 0, "R10 no early trigger", hits, 0);
        watch(p, 66000, hits, bad);
        check(hits == 1 && bad == 0, "R10 fires after wrap", hits, 1);
    endtask

    initial begin
        t_reset;
        t_count;
        t_corr(16'd100, "R3 positive correction");
        t_corr(16'hFF9C, "R3 negative correction");
        t_corr(16'hFFFF, "R3 minus one holds count");
        t_gate;
        t_fire;
        t_nosync;
        t_past;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule